// File: doc/BRIEF.md
# Wake-on-LAN Magic Packet Detector

This block watches a received Ethernet frame one byte per accepted beat and decides whether the frame is a wake-up magic packet. The first six bytes of every frame (the destination address field) are latched as the match address. No station address is programmed anywhere. From byte index 12 onward the block looks for a synchronisation run of six 0xFF bytes. The run must be followed at once by sixteen back-to-back copies of the latched address, compared in transmitted byte order. Filler bytes may sit before the run and after the last copy.

At the frame's last byte the verdict is formed: the pattern was seen, the frame's CRC was good, the external receive filter accepted the frame, and detection is enabled. If all four hold, two sticky flags are raised: a magic-packet status flag and a general wake flag. A one-cycle wake pulse is also issued. Each flag has its own write-one-to-clear input.

The byte input is a valid/ready stream. The block never applies back-pressure: `s_ready` is permanently high, so a beat is consumed on every clock edge where `s_valid` is high. Idle cycles, with `s_valid` low, may appear anywhere inside a frame and have no effect. `s_sof` and `s_eof` qualify the byte they accompany. `crc_ok`, `filt_accept` and `magic_en` are sampled only with the end-of-frame byte.

Top module: `wol_magic_detect`

## Requirements
- R1: `s_ready` is 1 from reset onward. A byte is consumed only when `s_valid` is 1. Beats that arrive outside a frame are ignored, and so is any end-of-frame marker on them. A frame runs from a beat with `s_sof`=1 through the next beat with `s_eof`=1.
- R2: The match address is the six bytes at frame byte indices 0..5, with index 0 compared first in each copy. A frame whose copies carry any other address gives no detection.
- R3: A detection needs exactly this sequence: at least six consecutive 0xFF bytes, then sixteen consecutive copies of the address (96 bytes). With fifteen copies, or with a run of only five 0xFF bytes, nothing is detected.
- R4: Any number of other bytes may precede the 0xFF run, and any number may follow the sixteenth copy before end-of-frame.
- R5: No flag is set and no pulse is issued when `filt_accept` is 0 on the end-of-frame byte.
- R6: No flag is set and no pulse is issued when `magic_en` is 0 on the end-of-frame byte.
- R7: No flag is set and no pulse is issued when `crc_ok` is 0 on the end-of-frame byte.
- R8: On a detection, `magic_status` and `wake_status` both read 1, and `wake_pulse` is 1 for exactly one cycle, all from the clock edge that consumes the end-of-frame byte. Both flags are 0 after reset. Both stay set until cleared.
- R9: `clr_magic`=1 clears `magic_status` on the next edge, and `clr_wake`=1 clears `wake_status` likewise. A 0 on either input has no effect, and each input clears only its own flag. A set on the same edge as a clear wins.
- R10: When a copy mismatches, the search restarts. A mismatching 0xFF byte counts as the first byte of a new 0xFF run, so overlapping patterns are still found.
- R11: Every `s_sof` beat resets all match state, even in the middle of a frame. A pattern split across such a boundary is not detected.
- R12: 0xFF bytes at frame indices below 12 never count toward the synchronisation run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Byte beat valid |
| s_ready | output | 1 | Always 1; the block never stalls |
| s_data | input | 8 | Received byte |
| s_sof | input | 1 | Beat is the first byte of a frame |
| s_eof | input | 1 | Beat is the last byte of a frame |
| crc_ok | input | 1 | CRC good, sampled with the end-of-frame beat |
| filt_accept | input | 1 | Receive filter accepted the frame, sampled with the end-of-frame beat |
| magic_en | input | 1 | Detection enable, sampled with the end-of-frame beat |
| clr_magic | input | 1 | Write-one-to-clear for magic_status |
| clr_wake | input | 1 | Write-one-to-clear for wake_status |
| magic_status | output | 1 | Sticky magic-packet detected flag |
| wake_status | output | 1 | Sticky wake-up flag |
| wake_pulse | output | 1 | One-cycle pulse on each detection |

## Verification
Every internal fault surfaces at a single instant: the clock edge that consumes the end-of-frame byte. A corrupted copy counter, 0xFF run counter or latched address byte shows up there as a missing or spurious `wake_pulse`, and as a wrong `magic_status` read on the same cycle. Nothing earlier is visible at the ports. For that reason each frame is paired with a known verdict, and the flags are compared immediately after its last byte. Clear and set interactions are visible one edge after the clear input is driven.

// File: rtl/wol_pkg.sv
package wol_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] octet_t;

  // Indices of the sticky flags kept by the status block.
  localparam int unsigned FLAG_MAGIC = 0;
  localparam int unsigned FLAG_WAKE  = 1;
  localparam int unsigned NUM_FLAGS  = 2;
endpackage

// File: rtl/wol_frame_tracker.sv
module wol_frame_tracker
  import wol_pkg::*;
#(
  parameter int unsigned ADDR_BYTES   = 6,
  parameter int unsigned SEARCH_START = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    beat_acc,
  input  logic                    beat_sof,
  input  logic                    beat_eof,
  input  octet_t                  beat_data,
  output logic                    frame_act,
  output logic                    search_ok,
  output logic [ADDR_BYTES*8-1:0] addr_flat
);
  localparam int unsigned IDX_W = $clog2(SEARCH_START + 1);
  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(SEARCH_START);

  logic                    in_frame_q;
  logic [IDX_W-1:0]        idx_q;
  logic [IDX_W-1:0]        idx_eff;
  logic [ADDR_BYTES*8-1:0] addr_q;

  // A beat belongs to a frame if it opens one or a frame is already open.
  assign frame_act = beat_acc & (beat_sof | in_frame_q);
  assign idx_eff   = beat_sof ? '0 : idx_q;
  assign search_ok = (idx_eff == IDX_MAX);
  assign addr_flat = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      idx_q      <= '0;
    end else if (frame_act) begin
      in_frame_q <= ~beat_eof;
      idx_q      <= search_ok ? IDX_MAX : idx_eff + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (frame_act) begin
      for (int k = 0; k < int'(ADDR_BYTES); k++) begin
        if (idx_eff == IDX_W'(k)) addr_q[8*k +: 8] <= beat_data;
      end
    end
  end

  // R2: once the search window is open the latched address no longer moves
  a_r2_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_act && !beat_sof && search_ok) |=> $stable(addr_q));
endmodule

// File: rtl/wol_pattern_match.sv
module wol_pattern_match
  import wol_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned REPS       = 16,
  parameter int unsigned SYNC_LEN   = 6,
  parameter logic [7:0]  SYNC_VAL   = 8'hFF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_act,
  input  logic                    beat_sof,
  input  logic                    search_ok,
  input  octet_t                  beat_data,
  input  logic [ADDR_BYTES*8-1:0] addr_flat,
  output logic                    match_seen
);
  localparam int unsigned SR_W  = $clog2(SYNC_LEN + 1);
  localparam int unsigned POS_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam int unsigned REP_W = (REPS > 1) ? $clog2(REPS) : 1;
  localparam logic [SR_W-1:0]  SR_MAX   = SR_W'(SYNC_LEN);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(ADDR_BYTES - 1);
  localparam logic [REP_W-1:0] REP_LAST = REP_W'(REPS - 1);

  logic [SR_W-1:0]  ff_q, ff_b, ff_n;
  logic             reps_q, reps_b, reps_n;
  logic [POS_W-1:0] pos_q, pos_b, pos_n;
  logic [REP_W-1:0] rep_q, rep_b, rep_n;
  logic             found_q, found_b;
  octet_t           exp_byte;
  logic             is_sync, rep_hit, pos_last, rep_last, hit_now;

  // A start-of-frame beat sees cleared state (R11).
  assign ff_b    = beat_sof ? '0   : ff_q;
  assign reps_b  = beat_sof ? 1'b0 : reps_q;
  assign pos_b   = beat_sof ? '0   : pos_q;
  assign rep_b   = beat_sof ? '0   : rep_q;
  assign found_b = beat_sof ? 1'b0 : found_q;

  assign exp_byte = addr_flat[8*pos_b +: 8];
  assign is_sync  = (beat_data == SYNC_VAL);
  assign rep_hit  = reps_b & search_ok & (beat_data == exp_byte);
  assign pos_last = (pos_b == POS_LAST);
  assign rep_last = (rep_b == REP_LAST);
  assign hit_now  = frame_act & rep_hit & pos_last & rep_last & ~found_b;

  assign match_seen = frame_act & (found_b | hit_now);

  always_comb begin
    // Running count of consecutive sync bytes, kept even during copies (R10).
    if (search_ok && is_sync) ff_n = (ff_b == SR_MAX) ? SR_MAX : ff_b + 1'b1;
    else                      ff_n = '0;

    reps_n = 1'b0;
    pos_n  = '0;
    rep_n  = '0;
    if (rep_hit && !(pos_last && rep_last)) begin
      reps_n = 1'b1;
      if (pos_last) begin
        pos_n = '0;
        rep_n = rep_b + 1'b1;
      end else begin
        pos_n = pos_b + 1'b1;
        rep_n = rep_b;
      end
    end else if (ff_n == SR_MAX) begin
      reps_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff_q    <= '0;
      reps_q  <= 1'b0;
      pos_q   <= '0;
      rep_q   <= '0;
      found_q <= 1'b0;
    end else if (frame_act) begin
      ff_q    <= ff_n;
      reps_q  <= reps_n;
      pos_q   <= pos_n;
      rep_q   <= rep_n;
      found_q <= found_b | hit_now;
    end
  end

  // R3: the copy phase can only be entered on a sync byte
  a_r3_reps_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reps_q) |-> $past(frame_act && beat_data == SYNC_VAL));
  // R11: a start-of-frame beat drops any earlier detection
  a_r11_sof_clears_found: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_act && beat_sof) |=> !found_q);
  // R10: a completed pattern is remembered for the rest of the frame
  a_r10_hit_remembered: assert property (@(posedge clk) disable iff (!rst_n)
    hit_now |=> found_q);
endmodule

// File: rtl/wol_wake_status.sv
module wol_wake_status
  import wol_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_evt,
  input  logic [NUM_FLAGS-1:0] clr_vec,
  output logic [NUM_FLAGS-1:0] flags,
  output logic                 pulse
);
  for (genvar g = 0; g < int'(NUM_FLAGS); g++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          f_q <= 1'b0;
      else if (set_evt)    f_q <= 1'b1;   // set beats clear (R9)
      else if (clr_vec[g]) f_q <= 1'b0;
    end
    assign flags[g] = f_q;

    // R9: a flag holds unless its own clear is written
    a_r9_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (f_q && !clr_vec[g]) |=> f_q);
    // R9: set and clear together leave the flag set
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt |=> f_q);
    // R9: a clear with no set empties the flag
    a_r9_clear_acts: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[g] && !set_evt) |=> !f_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= set_evt;
  end
endmodule

// File: rtl/wol_magic_detect.sv
module wol_magic_detect
  import wol_pkg::*;
#(
  parameter int unsigned ADDR_BYTES   = 6,
  parameter int unsigned REPS         = 16,
  parameter int unsigned SYNC_LEN     = 6,
  parameter int unsigned SEARCH_START = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       s_valid,
  output logic       s_ready,
  input  logic [7:0] s_data,
  input  logic       s_sof,
  input  logic       s_eof,
  input  logic       crc_ok,
  input  logic       filt_accept,
  input  logic       magic_en,
  input  logic       clr_magic,
  input  logic       clr_wake,
  output logic       magic_status,
  output logic       wake_status,
  output logic       wake_pulse
);
  logic                    beat_acc;
  logic                    frame_act;
  logic                    search_ok;
  logic [ADDR_BYTES*8-1:0] addr_flat;
  logic                    match_seen;
  logic                    set_evt;
  logic [NUM_FLAGS-1:0]    clr_vec;
  logic [NUM_FLAGS-1:0]    flags;

  assign s_ready  = 1'b1;
  assign beat_acc = s_valid & s_ready;

  wol_frame_tracker #(
    .ADDR_BYTES  (ADDR_BYTES),
    .SEARCH_START(SEARCH_START)
  ) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .beat_acc (beat_acc),
    .beat_sof (s_sof),
    .beat_eof (s_eof),
    .beat_data(s_data),
    .frame_act(frame_act),
    .search_ok(search_ok),
    .addr_flat(addr_flat)
  );

  wol_pattern_match #(
    .ADDR_BYTES(ADDR_BYTES),
    .REPS      (REPS),
    .SYNC_LEN  (SYNC_LEN),
    .SYNC_VAL  (8'hFF)
  ) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_act (frame_act),
    .beat_sof  (s_sof),
    .search_ok (search_ok),
    .beat_data (s_data),
    .addr_flat (addr_flat),
    .match_seen(match_seen)
  );

  // Verdict on the closing byte: pattern AND crc AND filter AND enable.
  assign set_evt = match_seen & s_eof & crc_ok & filt_accept & magic_en;

  assign clr_vec[FLAG_MAGIC] = clr_magic;
  assign clr_vec[FLAG_WAKE]  = clr_wake;

  wol_wake_status u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_evt(set_evt),
    .clr_vec(clr_vec),
    .flags  (flags),
    .pulse  (wake_pulse)
  );

  assign magic_status = flags[FLAG_MAGIC];
  assign wake_status  = flags[FLAG_WAKE];

  // R5: a rejected frame never wakes
  a_r5_filter_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_eof && !filt_accept) |=> !wake_pulse);
  // R6: disabled detection never wakes
  a_r6_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_eof && !magic_en) |=> !wake_pulse);
  // R7: a bad-CRC frame never wakes
  a_r7_crc_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_eof && !crc_ok) |=> !wake_pulse);
  // R8: the pulse comes with both flags raised
  a_r8_pulse_marks_both: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> (magic_status && wake_status));
  // R8: the pulse lasts a single cycle
  a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);
endmodule

// File: tb/wol_magic_detect_tb.sv
`timescale 1ns/1ps
module wol_magic_detect_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic s_valid, s_ready, s_sof, s_eof;
  logic [7:0] s_data;
  logic crc_ok, filt_accept, magic_en, clr_magic, clr_wake;
  logic magic_status, wake_status, wake_pulse;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  wol_magic_detect u_dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_sof(s_sof), .s_eof(s_eof), .crc_ok(crc_ok),
    .filt_accept(filt_accept), .magic_en(magic_en), .clr_magic(clr_magic),
    .clr_wake(clr_wake), .magic_status(magic_status),
    .wake_status(wake_status), .wake_pulse(wake_pulse)
  );

  localparam logic [47:0] ADDR_A = 48'h02_A5_3C_71_E8_94;
  localparam logic [47:0] ADDR_B = 48'h02_A5_3C_71_E8_95;

  logic [7:0] fr[$];
  bit         exp_q[$];
  string      tag_q[$];
  bit         exp_magic = 1'b0;
  bit         exp_wake  = 1'b0;
  bit         gap_mode  = 1'b0;
  logic       last_eof;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic put(input logic [7:0] b); fr.push_back(b); endtask
  task automatic put_addr(input logic [47:0] a);
    for (int k = 0; k < 6; k++) fr.push_back(a[47-8*k -: 8]);
  endtask
  task automatic put_hdr(input logic [47:0] a);
    put_addr(a);
    for (int k = 0; k < 6; k++) put(8'h30 + 8'(k));
    put(8'h08); put(8'h00);
  endtask
  task automatic put_fill(input int n);
    for (int k = 0; k < n; k++) put(8'h40 + 8'(k));
  endtask
  task automatic put_sync(input int n);
    for (int k = 0; k < n; k++) put(8'hFF);
  endtask
  task automatic put_reps(input logic [47:0] a, input int n);
    for (int k = 0; k < n; k++) put_addr(a);
  endtask

  // Driver: plays fr[] as one frame and pushes the expected verdict.
  task automatic send(input bit crc, input bit filt, input bit en, input bit e,
                      input bit clr_eof, input bit use_sof, input int sof_at,
                      input string tag);
    for (int i = 0; i < fr.size(); i++) begin
      if (gap_mode && (i % 7) == 3) begin
        @(negedge clk);
        s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0;
      end
      @(negedge clk);
      s_valid     = 1'b1;
      s_data      = fr[i];
      s_sof       = use_sof && (i == 0 || i == sof_at);
      s_eof       = (i == fr.size() - 1);
      crc_ok      = crc;
      filt_accept = filt;
      magic_en    = en;
      clr_magic   = clr_eof && (i == fr.size() - 1);
      if (i == fr.size() - 1) begin
        exp_q.push_back(e);
        tag_q.push_back(tag);
      end
    end
    @(negedge clk);
    s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0; clr_magic = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_magic(input bit v, input string tag);
    @(negedge clk); clr_magic = v;
    @(negedge clk); clr_magic = 1'b0;
    if (v) exp_magic = 1'b0;
    chk({tag, " magic_status"}, 32'(magic_status), 32'(exp_magic));
    chk({tag, " wake_status"}, 32'(wake_status), 32'(exp_wake));
  endtask

  task automatic clear_wake(input string tag);
    @(negedge clk); clr_wake = 1'b1;
    @(negedge clk); clr_wake = 1'b0;
    exp_wake = 1'b0;
    chk({tag, " wake_status"}, 32'(wake_status), 32'(exp_wake));
    chk({tag, " magic_status"}, 32'(magic_status), 32'(exp_magic));
  endtask

  // Monitor: samples the edge after each end-of-frame byte.
  always @(posedge clk) last_eof <= s_valid && s_eof;

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && last_eof) begin
        if (exp_q.size() == 0) begin
          chk("R8 unexpected end-of-frame", 32'd1, 32'd0);
        end else begin
          bit    e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (e) begin exp_magic = 1'b1; exp_wake = 1'b1; end
          chk({t, " wake_pulse"}, 32'(wake_pulse), 32'(e));
          chk({t, " magic_status"}, 32'(magic_status), 32'(exp_magic));
          chk({t, " wake_status"}, 32'(wake_status), 32'(exp_wake));
          if (e) begin
            @(negedge clk);
            chk({t, " R8 pulse one cycle"}, 32'(wake_pulse), 32'd0);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk("watchdog expired", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0; s_data = '0;
    crc_ok = 1'b0; filt_accept = 1'b0; magic_en = 1'b0;
    clr_magic = 1'b0; clr_wake = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", 32'(s_ready), 32'd1);
    chk("R8 reset magic_status", 32'(magic_status), 32'd0);
    chk("R8 reset wake_status", 32'(wake_status), 32'd0);
    chk("R8 reset wake_pulse", 32'(wake_pulse), 32'd0);

    // R3 plain magic packet
    fr.delete(); put_hdr(ADDR_A); put_sync(6); put_reps(ADDR_A, 16);
    send(1, 1, 1, 1, 0, 1, -1, "R3 basic");

    clear_magic(1, "R9 clear one");

    // R4 filler before and after
    fr.delete(); put_hdr(ADDR_A); put_fill(9); put_sync(6); put_reps(ADDR_A, 16); put_fill(5);
    send(1, 1, 1, 1, 0, 1, -1, "R4 filler");

    clear_magic(0, "R9 zero write");
    clear_magic(1, "R9 clear again");

    // R5 / R6 / R7 gating
    fr.delete(); put_hdr(ADDR_A); put_sync(6); put_reps(ADDR_A, 16);
    send(1, 0, 1, 0, 0, 1, -1, "R5 filter reject");
    send(1, 1, 0, 0, 0, 1, -1, "R6 disabled");
    send(0, 1, 1, 0, 0, 1, -1, "R7 bad crc");

    // R2 address comes from the frame
    fr.delete(); put_hdr(ADDR_A); put_sync(6); put_reps(ADDR_B, 16);
    send(1, 1, 1, 0, 0, 1, -1, "R2 wrong address");
    fr.delete(); put_hdr(ADDR_B); put_sync(6); put_reps(ADDR_B, 16);
    send(1, 1, 1, 1, 0, 1, -1, "R2 other frame address");

    // R3 boundaries
    fr.delete(); put_hdr(ADDR_A); put_sync(6); put_reps(ADDR_A, 15); put_fill(4);
    send(1, 1, 1, 0, 0, 1, -1, "R3 fifteen copies");
    fr.delete(); put_hdr(ADDR_A); put_fill(2); put_sync(5); put_reps(ADDR_A, 16);
    send(1, 1, 1, 0, 0, 1, -1, "R3 five sync bytes");

    // R10 restart and overlap
    fr.delete(); put_hdr(ADDR_A); put_sync(6); put_reps(ADDR_A, 3); put_sync(6); put_reps(ADDR_A, 16);
    send(1, 1, 1, 1, 0, 1, -1, "R10 ff breaks copy");
    fr.delete(); put_hdr(ADDR_A); put_sync(6); put_reps(ADDR_A, 5);
    put(8'h02); put(8'hA5); put(8'h3C); put(8'h00); put_sync(6); put_reps(ADDR_A, 16);
    send(1, 1, 1, 1, 0, 1, -1, "R10 mid copy mismatch");

    // R12 sync bytes inside the header window
    fr.delete(); put_addr(ADDR_A); put_sync(6); put_reps(ADDR_A, 16);
    send(1, 1, 1, 0, 0, 1, -1, "R12 early sync");

    // R11 start-of-frame in the middle of a pattern
    begin
      int at;
      fr.delete(); put_hdr(ADDR_A); put_sync(6); put_reps(ADDR_A, 10);
      at = fr.size();
      put_reps(ADDR_A, 7);
      send(1, 1, 1, 0, 0, 1, at, "R11 sof splits pattern");
    end

    // R1 idle beats inside a frame
    gap_mode = 1'b1;
    fr.delete(); put_hdr(ADDR_A); put_fill(3); put_sync(6); put_reps(ADDR_A, 16);
    send(1, 1, 1, 1, 0, 1, -1, "R1 valid gaps");
    gap_mode = 1'b0;

    // R1 bytes outside any frame
    fr.delete(); put_fill(14); put_sync(6); put_reps(ADDR_A, 16);
    send(1, 1, 1, 0, 0, 0, -1, "R1 no frame open");

    // R9 set and clear on the same edge
    clear_magic(1, "R9 pre clear");
    fr.delete(); put_hdr(ADDR_A); put_sync(6); put_reps(ADDR_A, 16);
    send(1, 1, 1, 1, 1, 1, -1, "R9 set wins");

    // R9 separate wake clear
    clear_wake("R9 wake clear");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule